// File: doc/BRIEF.md
# Flash and Torch Mode Sequencer

This block is the digital mode controller of a flash-LED driver that draws its energy from a supercapacitor. Software writes a command word that holds enables for power, flash, torch, monitoring, voltage hold during torch and charging. It also sets a flash duration code, a torch time limit code and an output-voltage code. Two hard-trigger pins are gated by the command bits. The sequencer moves among Shutdown, Monitoring, Idle, Flash and two Torch variants. Its outputs drive the flash and torch current enables, the charger enable, a flash-running status and single-cycle attention events.

A flash is timed by a down-counter that is loaded only when the command word is written. It decrements on a prescaled tick only while Flash is active. Time spent in Flash is therefore summed over every pin strobe until the next write. When the counter runs out, the sequencer clears its own flash bit and pulses an attention event. Torch time is limited by a millisecond timer that restarts on each torch entry. LED-hot and chip-overtemperature faults drop the sequencer to Idle. A stop from the light sensor ends a flash and pulses an overrun event.

Top module: `strobe_mode_ctrl`

## Requirements
- R1: After reset, `state_o` is 0 (Shutdown) and every enable, status and event output is 0. State codes: 0 Shutdown, 1 Monitoring, 2 Idle, 3 Flash, 4 Torch with voltage hold, 5 Torch in efficiency mode.
- R2: With the power bit clear, the sequencer goes to Shutdown on the next cycle from any state. The exception is Shutdown or Monitoring with the monitor bit set and a non-zero voltage code, which gives Monitoring. With the power bit set, Shutdown and Monitoring go to Idle.
- R3: From Idle, with no fault present, Flash is entered on the next cycle only when the flash bit, `flash_pin` and `cap_ready` are all 1.
- R4: `flash_en` and `flash_run` are 1 exactly while `state_o` is 3.
- R5: A command write loads the flash counter with `wr_ftim`. The total number of cycles spent in Flash before it times out is `wr_ftim`×FLASH_TICK_DIV+1. This total is summed across exits caused by dropping the pin.
- R6: On flash timeout, the state returns to Idle, `flash_cmd_o` drops to 0 and `attn_timeout` is high for exactly one cycle.
- R7: From Idle, the torch bit, `torch_pin` and `cap_ready` enter state 4 when the hold bit is 1, or state 5 when it is 0. `torch_en` is 1 in both states and `torch_hold_o` only in state 4.
- R8: Time limit code 0 places no limit on torch. Code k>0 ends torch after k×TORCH_STEP_MS×TORCH_TICK_DIV+1 cycles in a torch state. Expiry returns the sequencer to Idle and clears the torch bit.
- R9: Dropping the flash request or the torch request, whether the bit or the pin, returns the active mode to Idle on the next cycle.
- R10: `led_hot` or `chip_hot` during Flash or Torch forces Idle on the next cycle and blocks entry from Idle while it persists.
- R11: `lsens_stop` during Flash, with time remaining, returns to Idle, pulses `fl_ovr` for one cycle and clears the flash bit.
- R12: `charge_en` is 1 only when the charge bit is set and the state is Idle or Torch with hold.
- R13: During Torch, a ready flash request moves the sequencer to Flash.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_wr | input | 1 | Command word write strobe |
| wr_pwr | input | 1 | Power enable bit |
| wr_flash | input | 1 | Flash enable bit |
| wr_torch | input | 1 | Torch enable bit |
| wr_monitor | input | 1 | Monitoring enable bit |
| wr_hold | input | 1 | Hold supercap voltage during torch |
| wr_charge | input | 1 | Charger enable bit |
| wr_ftim | input | FTIM_W | Flash duration code |
| wr_tsel | input | TSEL_W | Torch time limit code |
| wr_vsel | input | VSEL_W | Output voltage code |
| flash_pin | input | 1 | Flash hard trigger |
| torch_pin | input | 1 | Torch hard trigger |
| cap_ready | input | 1 | Supercap charged flag |
| led_hot | input | 1 | LED overtemperature fault |
| chip_hot | input | 1 | Chip overtemperature fault |
| lsens_stop | input | 1 | Light sensor stop request |
| state_o | output | 3 | Current state code |
| flash_en | output | 1 | Flash current enable |
| torch_en | output | 1 | Torch current enable |
| torch_hold_o | output | 1 | Torch runs with voltage hold |
| charge_en | output | 1 | Charger enable |
| flash_run | output | 1 | Flash-running status |
| flash_cmd_o | output | 1 | Current value of the flash bit |
| attn_timeout | output | 1 | One-cycle flash timeout event |
| fl_ovr | output | 1 | One-cycle light-sensor stop event |

## Verification
Directed sequences cover the basic cases:
- A single uninterrupted flash, which checks the counter arithmetic.
- A flash broken by a dropped pin, which shows whether the count is held or restarted.
- Flash requests missing the ready flag or the pin, which separate true gating from a bit that is merely latched.
- Torch with and without a time limit, which separates state 4 from state 5 and shows whether expiry clears the command bit or lets torch re-enter.

Faults, light-sensor stops, power removal and flash requests during torch are then applied in the middle of a mode to show which cause takes priority. A long seeded random run mixes writes, pin toggles and rare faults. Its results are compared every cycle with a bench model that applies the requirements.

// File: rtl/smc_pkg.sv
package smc_pkg;

  typedef enum logic [2:0] {
    ST_OFF        = 3'd0,
    ST_WATCH      = 3'd1,
    ST_IDLE       = 3'd2,
    ST_FLASH      = 3'd3,
    ST_TORCH_HOLD = 3'd4,
    ST_TORCH_ECO  = 3'd5
  } smc_state_e;

  typedef struct packed {
    logic pwr;
    logic flash;
    logic torch;
    logic monitor;
    logic hold;
    logic charge;
  } smc_cmd_t;

  function automatic logic is_torch(smc_state_e s);
    return (s == ST_TORCH_HOLD) || (s == ST_TORCH_ECO);
  endfunction

  // milliseconds allowed in torch for a limit code (0 = unlimited)
  function automatic int unsigned torch_limit_ms(int unsigned sel, int unsigned step_ms);
    return sel * step_ms;
  endfunction

endpackage

// File: rtl/smc_prescale.sv
module smc_prescale #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic tick
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pre_q;

  assign tick = run && (pre_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pre_q <= '0;
    else if (clr) pre_q <= '0;
    else if (run) pre_q <= (pre_q == LAST) ? '0 : pre_q + 1'b1;
  end
endmodule

// File: rtl/smc_flash_timer.sv
module smc_flash_timer #(
  parameter int unsigned CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          dec,
  output logic [CW-1:0] cnt,
  output logic          zero
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (load)               cnt <= load_val;
    else if (dec && cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/smc_torch_timer.sv
module smc_torch_timer #(
  parameter int unsigned STEP_MS = 5000,
  parameter int unsigned SEL_W   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [SEL_W-1:0] sel,
  output logic             expire
);
  localparam int unsigned MS_MAX = ((1 << SEL_W) - 1) * STEP_MS;
  localparam int unsigned MW     = $clog2(MS_MAX + 1);

  logic [MW-1:0] ms_q;
  logic [MW-1:0] limit;

  assign limit = MW'(smc_pkg::torch_limit_ms(32'(sel), STEP_MS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               ms_q <= '0;
    else if (!run)                            ms_q <= '0;
    else if (tick && ms_q != MW'(MS_MAX))     ms_q <= ms_q + 1'b1;
  end

  assign expire = run && (sel != '0) && (ms_q >= limit);
endmodule

// File: rtl/smc_fsm.sv
module smc_fsm
  import smc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr,
  input  logic       mon_ok,
  input  logic       flash_req,
  input  logic       torch_req,
  input  logic       ready,
  input  logic       fault,
  input  logic       flash_stop,
  input  logic       torch_exp,
  input  logic       hold,
  output smc_state_e state
);
  smc_state_e nxt;
  smc_state_e torch_pick;

  assign torch_pick = hold ? ST_TORCH_HOLD : ST_TORCH_ECO;

  always_comb begin
    nxt = state;
    if (!pwr) begin
      nxt = ((state == ST_OFF || state == ST_WATCH) && mon_ok) ? ST_WATCH : ST_OFF;
    end else begin
      case (state)
        ST_OFF, ST_WATCH: nxt = ST_IDLE;
        ST_IDLE: begin
          if (!fault) begin
            if (flash_req && ready)      nxt = ST_FLASH;
            else if (torch_req && ready) nxt = torch_pick;
          end
        end
        ST_FLASH: begin
          if (fault || flash_stop || !flash_req) nxt = ST_IDLE;
        end
        ST_TORCH_HOLD, ST_TORCH_ECO: begin
          if (fault || torch_exp || !torch_req) nxt = ST_IDLE;
          else if (flash_req && ready)          nxt = ST_FLASH;
          else                                  nxt = torch_pick;
        end
        default: nxt = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_OFF;
    else        state <= nxt;
  end
endmodule

// File: rtl/strobe_mode_ctrl.sv
module strobe_mode_ctrl
  import smc_pkg::*;
#(
  parameter int unsigned FTIM_W         = 5,
  parameter int unsigned TSEL_W         = 2,
  parameter int unsigned VSEL_W         = 2,
  parameter int unsigned FLASH_TICK_DIV = 132000,
  parameter int unsigned TORCH_TICK_DIV = 10000,
  parameter int unsigned TORCH_STEP_MS  = 5000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic              wr_pwr,
  input  logic              wr_flash,
  input  logic              wr_torch,
  input  logic              wr_monitor,
  input  logic              wr_hold,
  input  logic              wr_charge,
  input  logic [FTIM_W-1:0] wr_ftim,
  input  logic [TSEL_W-1:0] wr_tsel,
  input  logic [VSEL_W-1:0] wr_vsel,
  input  logic              flash_pin,
  input  logic              torch_pin,
  input  logic              cap_ready,
  input  logic              led_hot,
  input  logic              chip_hot,
  input  logic              lsens_stop,
  output logic [2:0]        state_o,
  output logic              flash_en,
  output logic              torch_en,
  output logic              torch_hold_o,
  output logic              charge_en,
  output logic              flash_run,
  output logic              flash_cmd_o,
  output logic              attn_timeout,
  output logic              fl_ovr
);
  smc_cmd_t          cmd_q;
  logic [TSEL_W-1:0] tsel_q;
  logic [VSEL_W-1:0] vsel_q;
  smc_state_e        state;

  // named internal events
  logic              flash_req;
  logic              torch_req;
  logic              fault;
  logic              mon_ok;
  logic              in_flash;
  logic              in_torch;
  logic              ftick;
  logic              ttick;
  logic [FTIM_W-1:0] fcnt;
  logic              fcnt_zero;
  logic              flash_to_evt;
  logic              ovr_evt;
  logic              torch_exp;
  logic              attn_q;
  logic              ovr_q;

  assign flash_req    = cmd_q.flash && flash_pin;
  assign torch_req    = cmd_q.torch && torch_pin;
  assign fault        = led_hot || chip_hot;
  assign mon_ok       = cmd_q.monitor && (vsel_q != '0);
  assign in_flash     = (state == ST_FLASH);
  assign in_torch     = is_torch(state);
  assign flash_to_evt = in_flash && fcnt_zero;
  assign ovr_evt      = in_flash && lsens_stop && !fcnt_zero;

  // command word with self-clearing enables; a write always wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      tsel_q <= '0;
      vsel_q <= '0;
    end else if (cmd_wr) begin
      cmd_q.pwr     <= wr_pwr;
      cmd_q.flash   <= wr_flash;
      cmd_q.torch   <= wr_torch;
      cmd_q.monitor <= wr_monitor;
      cmd_q.hold    <= wr_hold;
      cmd_q.charge  <= wr_charge;
      tsel_q        <= wr_tsel;
      vsel_q        <= wr_vsel;
    end else begin
      if (flash_to_evt || ovr_evt) cmd_q.flash <= 1'b0;
      if (torch_exp)               cmd_q.torch <= 1'b0;
    end
  end

  smc_prescale #(.DIV(FLASH_TICK_DIV)) u_fpre (
    .clk(clk), .rst_n(rst_n), .clr(cmd_wr), .run(in_flash), .tick(ftick)
  );

  smc_flash_timer #(.CW(FTIM_W)) u_ftmr (
    .clk(clk), .rst_n(rst_n), .load(cmd_wr), .load_val(wr_ftim),
    .dec(ftick), .cnt(fcnt), .zero(fcnt_zero)
  );

  smc_prescale #(.DIV(TORCH_TICK_DIV)) u_tpre (
    .clk(clk), .rst_n(rst_n), .clr(!in_torch), .run(in_torch), .tick(ttick)
  );

  smc_torch_timer #(.STEP_MS(TORCH_STEP_MS), .SEL_W(TSEL_W)) u_ttmr (
    .clk(clk), .rst_n(rst_n), .run(in_torch), .tick(ttick),
    .sel(tsel_q), .expire(torch_exp)
  );

  smc_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .pwr(cmd_q.pwr), .mon_ok(mon_ok),
    .flash_req(flash_req), .torch_req(torch_req), .ready(cap_ready),
    .fault(fault), .flash_stop(flash_to_evt || ovr_evt),
    .torch_exp(torch_exp), .hold(cmd_q.hold), .state(state)
  );

  // one-cycle event pulses toward the status latch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      attn_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      attn_q <= flash_to_evt;
      ovr_q  <= ovr_evt;
    end
  end

  assign state_o      = state;
  assign flash_en     = in_flash;
  assign flash_run    = in_flash;
  assign torch_en     = in_torch;
  assign torch_hold_o = (state == ST_TORCH_HOLD);
  assign charge_en    = cmd_q.charge && (state == ST_IDLE || state == ST_TORCH_HOLD);
  assign flash_cmd_o  = cmd_q.flash;
  assign attn_timeout = attn_q;
  assign fl_ovr       = ovr_q;
endmodule

// File: rtl/strobe_mode_ctrl_chk.sv
module strobe_mode_ctrl_chk #(
  parameter int unsigned FTIM_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_wr,
  input logic              pwr_q,
  input logic              torch_cmd_q,
  input logic              flash_req,
  input logic              torch_req,
  input logic              cap_ready,
  input logic              fault,
  input logic [2:0]        state_o,
  input logic              ftick,
  input logic [FTIM_W-1:0] fcnt,
  input logic              fcnt_zero,
  input logic              flash_to_evt,
  input logic              ovr_evt,
  input logic              torch_exp,
  input logic              flash_cmd_o,
  input logic              attn_timeout,
  input logic              fl_ovr
);
  logic active;
  assign active = (state_o == 3'd3) || (state_o == 3'd4) || (state_o == 3'd5);

  p_pwr_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_q |=> (state_o == 3'd0 || state_o == 3'd1));

  p_flash_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd2 && pwr_q && flash_req && cap_ready && !fault) |=> state_o == 3'd3);

  p_count_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ftick && !fcnt_zero && !cmd_wr) |=> fcnt == $past(fcnt) - 1'b1);

  p_timeout_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flash_to_evt && pwr_q && !cmd_wr) |=> (attn_timeout && !flash_cmd_o && state_o == 3'd2));

  p_attn_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    attn_timeout |=> !attn_timeout);

  p_torch_expiry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (torch_exp && pwr_q && !cmd_wr) |=> (state_o == 3'd2 && !torch_cmd_q));

  p_drop_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd3 && pwr_q && !flash_req) |=> state_o == 3'd2);

  p_torch_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_o == 3'd4 || state_o == 3'd5) && pwr_q && !torch_req) |=> state_o == 3'd2);

  p_fault_exit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (active && fault && pwr_q) |=> state_o == 3'd2);

  p_ovr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_evt && !cmd_wr) |=> (fl_ovr && !flash_cmd_o));
endmodule

bind strobe_mode_ctrl strobe_mode_ctrl_chk #(.FTIM_W(FTIM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .pwr_q(cmd_q.pwr),
  .torch_cmd_q(cmd_q.torch), .flash_req(flash_req), .torch_req(torch_req),
  .cap_ready(cap_ready), .fault(fault), .state_o(state_o), .ftick(ftick),
  .fcnt(fcnt), .fcnt_zero(fcnt_zero), .flash_to_evt(flash_to_evt),
  .ovr_evt(ovr_evt), .torch_exp(torch_exp), .flash_cmd_o(flash_cmd_o),
  .attn_timeout(attn_timeout), .fl_ovr(fl_ovr)
);

// File: tb/tb_strobe_mode_ctrl.sv
module tb_strobe_mode_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int FDIV  = 4;
  localparam int TDIV  = 3;
  localparam int TSTEP = 5;
  localparam int WD_CYCLES = 60000;
  localparam int SEED = 1234;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_wr = 0, wr_pwr = 0, wr_flash = 0, wr_torch = 0, wr_monitor = 0, wr_hold = 0, wr_charge = 0;
  logic [4:0] wr_ftim = 0;
  logic [1:0] wr_tsel = 0, wr_vsel = 0;
  logic flash_pin = 0, torch_pin = 0, cap_ready = 0, led_hot = 0, chip_hot = 0, lsens_stop = 0;
  logic [2:0] state_o;
  logic flash_en, torch_en, torch_hold_o, charge_en, flash_run, flash_cmd_o, attn_timeout, fl_ovr;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // bench model of the requirements
  int m_st, m_fcnt, m_fpre, m_tpre, m_tms, m_tsel, m_vsel;
  bit m_pwr, m_fl, m_tc, m_mon, m_hold, m_chg, m_attn, m_ovr;

  always #(CLK_PERIOD/2) clk = ~clk;

  strobe_mode_ctrl #(
    .FLASH_TICK_DIV(FDIV), .TORCH_TICK_DIV(TDIV), .TORCH_STEP_MS(TSTEP)
  ) dut (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .wr_pwr(wr_pwr), .wr_flash(wr_flash),
    .wr_torch(wr_torch), .wr_monitor(wr_monitor), .wr_hold(wr_hold), .wr_charge(wr_charge),
    .wr_ftim(wr_ftim), .wr_tsel(wr_tsel), .wr_vsel(wr_vsel), .flash_pin(flash_pin),
    .torch_pin(torch_pin), .cap_ready(cap_ready), .led_hot(led_hot), .chip_hot(chip_hot),
    .lsens_stop(lsens_stop), .state_o(state_o), .flash_en(flash_en), .torch_en(torch_en),
    .torch_hold_o(torch_hold_o), .charge_en(charge_en), .flash_run(flash_run),
    .flash_cmd_o(flash_cmd_o), .attn_timeout(attn_timeout), .fl_ovr(fl_ovr)
  );

  function automatic int exp_flash_cycles(int ftim);
    return ftim * FDIV + 1;
  endfunction

  function automatic int exp_torch_cycles(int code);
    return code * TSTEP * TDIV + 1;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_st = 0; m_fcnt = 0; m_fpre = 0; m_tpre = 0; m_tms = 0; m_tsel = 0; m_vsel = 0;
    m_pwr = 0; m_fl = 0; m_tc = 0; m_mon = 0; m_hold = 0; m_chg = 0; m_attn = 0; m_ovr = 0;
  endtask

  task automatic model_step();
    int nst, lim;
    bit freq, treq, flt, monok, intc, tmo, ovr, ex;
    freq  = m_fl && flash_pin;
    treq  = m_tc && torch_pin;
    flt   = led_hot || chip_hot;
    monok = m_mon && (m_vsel != 0);
    intc  = (m_st == 4 || m_st == 5);
    tmo   = (m_st == 3) && (m_fcnt == 0);
    ovr   = (m_st == 3) && lsens_stop && (m_fcnt != 0);
    lim   = m_tsel * TSTEP;
    ex    = intc && (m_tsel != 0) && (m_tms >= lim);
    nst = m_st;
    if (!m_pwr) nst = ((m_st == 0 || m_st == 1) && monok) ? 1 : 0;
    else if (m_st <= 1) nst = 2;
    else if (m_st == 2) begin
      if (!flt) begin
        if (freq && cap_ready) nst = 3;
        else if (treq && cap_ready) nst = m_hold ? 4 : 5;
      end
    end else if (m_st == 3) begin
      if (flt || tmo || ovr || !freq) nst = 2;
    end else begin
      if (flt || ex || !treq) nst = 2;
      else if (freq && cap_ready) nst = 3;
      else nst = m_hold ? 4 : 5;
    end
    if (cmd_wr) begin m_fcnt = int'(wr_ftim); m_fpre = 0; end
    else if (m_st == 3) begin
      if (m_fpre == FDIV - 1) begin m_fpre = 0; if (m_fcnt != 0) m_fcnt--; end
      else m_fpre++;
    end
    if (!intc) begin m_tpre = 0; m_tms = 0; end
    else if (m_tpre == TDIV - 1) begin m_tpre = 0; if (m_tms < 3 * TSTEP) m_tms++; end
    else m_tpre++;
    if (cmd_wr) begin
      m_pwr = wr_pwr; m_fl = wr_flash; m_tc = wr_torch; m_mon = wr_monitor;
      m_hold = wr_hold; m_chg = wr_charge; m_tsel = int'(wr_tsel); m_vsel = int'(wr_vsel);
    end else begin
      if (tmo || ovr) m_fl = 0;
      if (ex) m_tc = 0;
    end
    m_attn = tmo; m_ovr = ovr; m_st = nst;
  endtask

  task automatic cmp(string tag);
    logic [10:0] act, exp;
    act = {state_o, flash_en, torch_en, torch_hold_o, charge_en, flash_run, flash_cmd_o, attn_timeout, fl_ovr};
    exp = {3'(m_st), m_st == 3, m_st >= 4, m_st == 4, m_chg && (m_st == 2 || m_st == 4),
           m_st == 3, m_fl, m_attn, m_ovr};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s outputs actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(string tag);
    model_step();
    @(negedge clk);
    cmp(tag);
  endtask

  task automatic run_n(int n, string tag);
    for (int i = 0; i < n; i++) cyc(tag);
  endtask

  task automatic wr(bit p, bit f, bit t, bit mo, bit h, bit c, int ft, int ts, int vs, string tag);
    cmd_wr = 1; wr_pwr = p; wr_flash = f; wr_torch = t; wr_monitor = mo; wr_hold = h; wr_charge = c;
    wr_ftim = 5'(ft); wr_tsel = 2'(ts); wr_vsel = 2'(vs);
    cyc(tag);
    cmd_wr = 0;
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog actual=expired expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int cnt, att;
    void'($urandom(SEED));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk(state_o == 3'd0 && !flash_en && !torch_en && !charge_en && !flash_run &&
        !attn_timeout && !fl_ovr && !flash_cmd_o && !torch_hold_o, "R1 reset", int'(state_o), 0);
    cmp("R1");

    // R2 monitoring then idle
    wr(0, 0, 0, 1, 0, 0, 0, 0, 1, "R2");
    cyc("R2");
    chk(state_o == 3'd1, "R2 monitoring", int'(state_o), 1);
    wr(1, 0, 0, 0, 0, 0, 0, 0, 1, "R2");
    cyc("R2");
    chk(state_o == 3'd2, "R2 idle", int'(state_o), 2);

    // R5 / R6 single flash
    cap_ready = 1; flash_pin = 1;
    wr(1, 1, 0, 0, 0, 0, 3, 0, 1, "R5");
    cnt = 0; att = 0;
    for (int i = 0; i < 40; i++) begin
      cyc("R5");
      if (state_o == 3'd3) cnt++;
      if (attn_timeout) att++;
    end
    chk(cnt == exp_flash_cycles(3), "R5 flash length", cnt, exp_flash_cycles(3));
    chk(att == 1, "R6 attention pulse count", att, 1);
    chk(!flash_cmd_o && state_o == 3'd2, "R6 flash bit cleared", int'(flash_cmd_o), 0);

    // R5 accumulation across strobes
    wr(1, 1, 0, 0, 0, 0, 5, 0, 1, "R5");
    cnt = 0;
    for (int i = 0; i < 9; i++) begin cyc("R5"); if (state_o == 3'd3) cnt++; end
    flash_pin = 0;
    for (int i = 0; i < 5; i++) begin cyc("R9"); if (state_o == 3'd3) cnt++; end
    chk(state_o == 3'd2, "R9 flash pin drop", int'(state_o), 2);
    flash_pin = 1;
    for (int i = 0; i < 40; i++) begin cyc("R5"); if (state_o == 3'd3) cnt++; end
    chk(cnt == exp_flash_cycles(5), "R5 summed length", cnt, exp_flash_cycles(5));

    // R3 gating
    cap_ready = 0;
    wr(1, 1, 0, 0, 0, 0, 2, 0, 1, "R3");
    run_n(8, "R3");
    chk(state_o == 3'd2, "R3 no ready", int'(state_o), 2);
    cap_ready = 1; flash_pin = 0;
    run_n(8, "R3");
    chk(state_o == 3'd2, "R3 no pin", int'(state_o), 2);
    flash_pin = 1;
    cyc("R3");
    chk(state_o == 3'd3 && flash_run, "R4 flash entry", int'(state_o), 3);
    run_n(15, "R5");

    // R7 / R8 torch with limit and hold
    torch_pin = 1; flash_pin = 0;
    wr(1, 0, 1, 0, 1, 1, 0, 1, 1, "R8");
    cnt = 0;
    for (int i = 0; i < 40; i++) begin
      cyc("R8");
      if (state_o == 3'd4 && torch_hold_o && torch_en && charge_en) cnt++;
    end
    chk(cnt == exp_torch_cycles(1), "R8 torch length", cnt, exp_torch_cycles(1));
    chk(state_o == 3'd2 && charge_en, "R12 charge in idle", int'(charge_en), 1);

    // R8 unlimited, R7 efficiency state
    wr(1, 0, 1, 0, 0, 0, 2, 0, 1, "R8");
    run_n(200, "R8");
    chk(state_o == 3'd5 && !torch_hold_o && torch_en, "R7 efficiency torch", int'(state_o), 5);

    // R13 flash preempts torch
    flash_pin = 1;
    wr(1, 1, 1, 0, 0, 0, 2, 0, 1, "R13");
    cyc("R13");
    chk(state_o == 3'd3, "R13 preempt", int'(state_o), 3);
    run_n(12, "R13");
    chk(state_o == 3'd5, "R13 torch resumes", int'(state_o), 5);

    // R10 fault during torch
    led_hot = 1;
    cyc("R10");
    chk(state_o == 3'd2, "R10 torch fault", int'(state_o), 2);
    run_n(5, "R10");
    chk(state_o == 3'd2, "R10 entry blocked", int'(state_o), 2);
    led_hot = 0;
    cyc("R10");
    torch_pin = 0;
    cyc("R9");
    chk(state_o == 3'd2, "R9 torch pin drop", int'(state_o), 2);

    // R10 chip fault in flash
    wr(1, 1, 0, 0, 0, 0, 9, 0, 1, "R10");
    run_n(3, "R10");
    chip_hot = 1;
    cyc("R10");
    chk(state_o == 3'd2, "R10 flash fault", int'(state_o), 2);
    chip_hot = 0;
    run_n(3, "R10");

    // R11 light stop
    lsens_stop = 1;
    cyc("R11");
    chk(state_o == 3'd2, "R11 stop to idle", int'(state_o), 2);
    chk(fl_ovr && !flash_cmd_o, "R11 overrun pulse", int'(fl_ovr), 1);
    lsens_stop = 0;
    cyc("R11");
    chk(!fl_ovr, "R11 pulse single", int'(fl_ovr), 0);

    // R2 power drop mid flash
    wr(1, 1, 0, 0, 0, 1, 20, 0, 1, "R2");
    run_n(3, "R12");
    chk(state_o == 3'd3 && !charge_en, "R12 no charge in flash", int'(charge_en), 0);
    wr(0, 1, 0, 0, 0, 0, 20, 0, 0, "R2");
    cyc("R2");
    chk(state_o == 3'd0, "R2 power drop", int'(state_o), 0);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      cmd_wr = ($urandom_range(0, 19) == 0);
      wr_pwr = ($urandom_range(0, 9) != 0);
      wr_flash = 1'($urandom); wr_torch = 1'($urandom); wr_monitor = 1'($urandom);
      wr_hold = 1'($urandom); wr_charge = 1'($urandom);
      wr_ftim = 5'($urandom_range(0, 8)); wr_tsel = 2'($urandom); wr_vsel = 2'($urandom);
      if ($urandom_range(0, 7) == 0) flash_pin = ~flash_pin;
      if ($urandom_range(0, 7) == 0) torch_pin = ~torch_pin;
      cap_ready  = ($urandom_range(0, 5) != 0);
      led_hot    = ($urandom_range(0, 40) == 0);
      chip_hot   = ($urandom_range(0, 60) == 0);
      lsens_stop = ($urandom_range(0, 30) == 0);
      cyc("R9 random");
    end
    cmd_wr = 0;

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule